// File: doc/BRIEF.md
# Variable-Divider Dot Clock Generator

This block derives two clock enables from a single master clock: a dot enable that marks the end of each dot period, and a pixel enable at half that rate. In narrow mode every dot period is five master clocks long. In wide mode most dot periods are four master clocks long, but a fixed pattern of five-clock periods is inserted around horizontal sync and the start of the front porch. Both modes therefore produce a line of exactly 3420 master clocks, although the wide line has more dots.

The horizontal counter is kept outside this block. The block reads the 9-bit counter value and its half-pixel phase bit for the dot tick in progress. The counter must advance by one half-pixel after each dot enable. The counter value is decoded only on entry to the sync region, at counter 0x1CD phase 0. From there an internal dot-tick index sequences the 66 ticks of the pattern. The mode select input is sampled only when the last tick of a line completes (counter 0x1FF, phase 1), so a change never splits a line.

Top module: `dot_clock_gen`

## Requirements
- R1: In narrow mode (mode select low at the last line wrap), every dot period is 5 master clocks, giving 684 dot ticks per line.
- R2: In wide mode, a dot tick is 4 master clocks unless its counter value lies from 0x1CD through 0x1ED.
- R3: In wide mode, take the ticks from counter 0x1CD phase 0 onward in order, with tick offset t = 2*(counter-0x1CD)+phase for t = 0..63. Tick offsets 15, 16, 32, 33, 49 and 50 last 4 master clocks. Every other tick in this range lasts 5.
- R4: In wide mode, both ticks at counter 0x1ED (phase 0 and phase 1) last 5 master clocks.
- R5: Every line, from counter 0x000 phase 0 to the end of 0x1FF phase 1, spans 3420 master clocks in either mode.
- R6: The pixel enable is high only together with the dot enable, and only on ticks whose phase bit is 1, so it fires on every second dot enable.
- R7: The dot enable is high for exactly one master clock at the end of each dot period, and no two dot enables are closer than 4 clocks.
- R8: While reset is asserted, both enables are low. After reset the first dot period starts fresh at counter 0x000 phase 0 and ends after 5 (narrow) or 4 (wide) clocks. The mode select value present during reset is taken as the mode.
- R9: A change of mode select in the middle of a line has no effect on that line. Only the value present when the line wraps applies to the next line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | Mode select: 1 wide, 0 narrow |
| hcount | input | 9 | Horizontal counter value of the current dot tick |
| hhalf | input | 1 | Half-pixel phase of the current dot tick |
| dot_en | output | 1 | One-clock pulse at the end of each dot period |
| pix_en | output | 1 | One-clock pulse at the end of each pixel |

## Verification
The hardest case to reach is a mode select that moves in the middle of a line. The wrong behaviour would switch the divider mid-line or be caught by a line wrap, and it shows only as a changed period many ticks later. The bench models the external counter tick by tick and times every dot period against a position-based decode of the pattern. Some of its lines toggle the mode select partway through and restore it before the wrap. A reset in the middle of a wide line, while the divider is inside a period, checks that the block restarts cleanly at counter 0x000.

// File: rtl/dot_clock_gen.sv
module dot_clock_gen #(
  parameter int          HW           = 9,
  parameter logic [8:0]  SYNC_START   = 9'h1CD,
  parameter logic [8:0]  LINE_LAST    = 9'h1FF,
  parameter int          REGION_TICKS = 66,
  parameter int          SEG_TICKS    = 17,
  parameter int          SEG_COUNT    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide_mode,
  input  logic [HW-1:0] hcount,
  input  logic          hhalf,
  output logic          dot_en,
  output logic          pix_en
);
  localparam int IW        = $clog2(REGION_TICKS + 1);
  localparam int SHORT_END = SEG_TICKS * SEG_COUNT;

  logic [2:0]    cnt;
  logic [IW-1:0] idx;
  logic          run, ph, mode_q;
  logic          entry, in_reg, shorted, slow, line_end;
  logic [IW-1:0] k;

  assign entry    = mode_q & ~run & (hcount == HW'(SYNC_START)) & ~hhalf;
  assign in_reg   = run | entry;
  assign k        = run ? idx : '0;
  assign shorted  = (int'(k) < SHORT_END) && ((int'(k) % SEG_TICKS) >= SEG_TICKS - 2);
  assign slow     = ~mode_q | (in_reg & ~shorted);
  assign dot_en   = (cnt == (slow ? 3'd4 : 3'd3));
  assign pix_en   = dot_en & ph;
  assign line_end = (hcount == HW'(LINE_LAST)) & hhalf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      ph     <= 1'b0;
      run    <= 1'b0;
      idx    <= '0;
      mode_q <= wide_mode;
    end else begin
      cnt <= dot_en ? 3'd0 : cnt + 3'd1;
      if (dot_en) begin
        ph <= ~ph;
        if (entry) begin
          run <= 1'b1;
          idx <= IW'(1);
        end else if (run) begin
          if (int'(idx) == REGION_TICKS - 1) begin
            run <= 1'b0;
            idx <= '0;
          end else begin
            idx <= idx + IW'(1);
          end
        end
        if (line_end) mode_q <= wide_mode;
      end
    end
  end

  p_pix_with_dot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |-> dot_en);

  p_pix_alternate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |=> (!pix_en && !dot_en));

  p_dot_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dot_en |-> (!$past(dot_en) && !$past(dot_en, 2) && !$past(dot_en, 3)));

  p_narrow_five_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && dot_en) |-> (!$past(dot_en) && !$past(dot_en, 2) &&
                             !$past(dot_en, 3) && !$past(dot_en, 4)));

  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(dot_en && line_end) |=> $stable(mode_q));

endmodule

// File: tb/dot_clock_gen_test.sv
module dot_clock_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wide_mode = 1'b0;
  logic [8:0] hcount = 9'h000;
  logic       hhalf = 1'b0;
  logic       dot_en, pix_en;

  int checks = 0;
  int fails  = 0;
  int gap    = 0;
  bit done_all = 0;

  always #2 clk = ~clk;

  dot_clock_gen uut (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
    .hcount(hcount), .hhalf(hhalf), .dot_en(dot_en), .pix_en(pix_en)
  );

  // bit1: mode to present for the next line, bit0: toggle mode mid-line
  localparam logic [1:0] VEC [6] = '{2'b10, 2'b11, 2'b01, 2'b00, 2'b10, 2'b00};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (h=%03h.%0d)", req, act, exp, hcount, hhalf);
    end
  endtask

  function automatic int exp_period(input logic lm, input logic [8:0] hc, input logic hf);
    int t;
    if (!lm) return 5;
    if (hc >= 9'h1CD && hc <= 9'h1EC) begin
      t = 2 * (int'(hc) - 'h1CD) + int'(hf);
      if (t == 15 || t == 16 || t == 32 || t == 33 || t == 49 || t == 50) return 4;
      return 5;
    end
    if (hc == 9'h1ED) return 5;
    return 4;
  endfunction

  function automatic string req_of(input logic lm, input logic [8:0] hc);
    if (!lm) return "R1";
    if (hc >= 9'h1CD && hc <= 9'h1EC) return "R3";
    if (hc == 9'h1ED) return "R4";
    return "R2";
  endfunction

  task automatic advance(input logic lm);
    if (!hhalf) hhalf = 1'b1;
    else begin
      hhalf = 1'b0;
      if (!lm && hcount == 9'h127) hcount = 9'h1D2;
      else if (lm && hcount == 9'h16C) hcount = 9'h1C9;
      else hcount = hcount + 9'h001;
    end
  endtask

  // runs ticks in mode lm; stops after max_ticks or at line wrap
  task automatic run_line(input logic lm, input logic nmode, input bit glitch, input int max_ticks);
    int ticks = 0;
    int line_clk = 0;
    bit wrapped = 0;
    wide_mode = nmode;
    while (!wrapped && ticks < max_ticks) begin
      @(negedge clk);
      gap++;
      if (gap > 5) begin
        check(0, "R7", gap, exp_period(lm, hcount, hhalf));
        gap = 0;
      end
      if (dot_en) begin
        check(gap == exp_period(lm, hcount, hhalf), req_of(lm, hcount), gap,
              exp_period(lm, hcount, hhalf));
        check(pix_en == hhalf, "R6", int'(pix_en), int'(hhalf));
        line_clk += gap;
        gap = 0;
        wrapped = (hcount == 9'h1FF) && hhalf;
        @(posedge clk);
        #1;
        advance(lm);
        ticks++;
        if (glitch && ticks == 100) wide_mode = ~nmode;  // R9 stimulus
        if (glitch && ticks == 400) wide_mode = nmode;
      end else begin
        check(!pix_en, "R6", int'(pix_en), 0);
      end
    end
    if (wrapped) check(line_clk == 3420, "R5", line_clk, 3420);
  endtask

  initial begin
    logic cur;
    repeat (3) begin
      @(negedge clk);
      check(!dot_en && !pix_en, "R8", int'(dot_en) + int'(pix_en), 0);
    end
    rst_n = 1'b1;
    gap = 1;
    cur = 1'b0;
    run_line(cur, VEC[0][1], VEC[0][0], 100000);
    for (int i = 1; i < 6; i++) begin
      cur = VEC[i-1][1];
      run_line(cur, VEC[i][1], VEC[i][0], 100000);
    end
    cur = VEC[5][1];
    // directed: reset in the middle of a wide line (R8)
    run_line(cur, 1'b1, 1'b0, 100000);
    run_line(1'b1, 1'b1, 1'b0, 201);
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    hcount = 9'h000;
    hhalf = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(!dot_en && !pix_en, "R8", int'(dot_en) + int'(pix_en), 0);
    end
    rst_n = 1'b1;
    gap = 1;
    run_line(1'b1, 1'b1, 1'b0, 100000);
    done_all = 1;
  end

  initial begin
    int cyc = 0;
    while (!done_all && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done_all) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule